// File: doc/BRIEF.md
# Capture/Compare Timer Channel with Write Arbitration

One timer channel built around a free-running up-counter and a single general register. The register can hold a compare value, written over a small two-cycle register bus. It can also hold a captured count, taken when a rising edge arrives on a synchronized capture input. While the counter runs and equals the general register, a compare match applies a chosen action to one output pin. An initial-level bit decides what the pin shows until a match changes it.

Bus writes and hardware events can land on the same clock edge, and fixed priorities settle them. A capture beats a general-register write. An output-control write beats a compare-driven pin change. A capture beats a software clear of the capture flag. A guarded mode field selects normal, reset-synchronous PWM or complementary PWM operation. The waveforms of those modes are not generated here. The mode field accepts a change only while the counter is stopped, and never directly from one PWM flavour to the other.

The bus is a plain write port with no back-pressure. A cycle with `bus_t1` high is the address phase (T1). The following cycle is the data phase (T2), and `bus_wdata` is sampled at its closing edge. A new T1 may overlap a T2. Reads are combinational through `rd_addr`. Register addresses: 0 general register, 1 output control, 2 channel control, 3 capture flag.

Top module: `capcmp_channel`

## Requirements
- R1: While the run bit is 1 the counter advances by one per clock, wrapping modulo 2^CNT_W. While it is 0 the counter holds its value. After reset it is 0.
- R2: `cap_in` passes two synchronizer flops and an edge-detect flop. If it is sampled high at edge k after being low at edge k-1, the general register is loaded at edge k+2 with the count present just before that edge.
- R3: A capture sets the capture flag (address 3, bit 0). A bus write of 1 to bit 0 of address 3 clears it. A capture on the same edge as that clear leaves the flag set.
- R4: A write to address 0 updates the general register at the end of T2 only. If a capture happens at that same edge, the captured count is stored and the bus data is discarded.
- R5: When run is 1 and the count equals the general register at an edge, that edge applies the action field to the pin: 00 keep, 01 drive 0, 10 drive 1, 11 invert.
- R6: After reset the pin, the initial-level bit and the action field are 0. A write to address 1 stores the initial level (bit 0) and the action (bits 2:1), and loads the pin with the new initial level. If a compare match falls on the same edge, the write wins and the match action is dropped.
- R7: Reading address 1 returns {action, initial level} from the register, not the pin level.
- R8: Address 2 holds run (bit 0) and mode (bits 2:1; 00 normal, 01 reset-synchronous PWM, 10 complementary PWM, 11 reserved). A write always updates run. The mode changes only if run was 0 before the write; otherwise the mode part is ignored.
- R9: A mode write of 11 is rejected. So is a direct change between 01 and 10. Either PWM mode must first return to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_in | input | 1 | Asynchronous capture input |
| bus_t1 | input | 1 | Address phase strobe; next cycle is the data phase |
| bus_addr | input | 2 | Register address, valid with bus_t1 |
| bus_wdata | input | CNT_W | Write data, valid in the data phase |
| rd_addr | input | 2 | Read address |
| rd_data | output | CNT_W | Combinational read data |
| cnt_o | output | CNT_W | Current counter value |
| cap_flag | output | 1 | Capture flag |
| cmp_pin | output | 1 | Compare output pin |

## Verification
The collisions are the hardest states to reach from the ports. A capture edge must leave the three-flop synchronizer on exactly the data-phase edge of a general-register write. An output-control data phase must fall on the edge where the running count reaches the general register. The stimulus reads the live count, then places the capture transition two edges ahead of the write's data phase. It also loads the general register with the count plus a fixed offset and times the output-control transaction to end on that edge. Random traffic biases compare values near the live count so that plain matches happen too.

// File: rtl/cc_pkg.sv
`timescale 1ns/1ps
package cc_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_RSYNC  = 2'b01,
    MODE_COMPL  = 2'b10,
    MODE_RSVD   = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'b00,
    ACT_CLR  = 2'b01,
    ACT_SET  = 2'b10,
    ACT_TGL  = 2'b11
  } act_e;

  localparam logic [1:0] A_GR   = 2'd0;
  localparam logic [1:0] A_OC   = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam logic [1:0] A_FLAG = 2'd3;
endpackage

// File: rtl/cc_counter.sv
`timescale 1ns/1ps
module cc_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (run) cnt <= cnt + W'(1);
  end

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> cnt == $past(cnt) + W'(1));
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt));
endmodule

// File: rtl/cc_capture_reg.sv
`timescale 1ns/1ps
module cc_capture_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_in,
  input  logic [W-1:0] cnt,
  input  logic         wr_gr,
  input  logic [W-1:0] wdata,
  input  logic         clr_flag,
  output logic [W-1:0] gr,
  output logic         flag
);
  localparam int SYNC_N = 3;
  logic [SYNC_N-1:0] sync_q;
  logic              cap_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_N-2:0], cap_in};
  end

  assign cap_edge = sync_q[SYNC_N-2] & ~sync_q[SYNC_N-1];

  // capture has priority over the bus write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gr <= '0;
    else if (cap_edge) gr <= cnt;
    else if (wr_gr)    gr <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (cap_edge) flag <= 1'b1;
    else if (clr_flag) flag <= 1'b0;
  end

  p_cap_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_edge |=> gr == $past(cnt));
  p_wr_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_gr && !cap_edge) |=> gr == $past(wdata));
  p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_edge |=> flag);
endmodule

// File: rtl/cc_pin_ctrl.sv
`timescale 1ns/1ps
module cc_pin_ctrl
  import cc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       oc_wr,
  input  logic [2:0] oc_wdata,
  input  logic       match,
  output logic       init_q,
  output act_e       act_q,
  output logic       pin
);
  logic pin_nxt;

  always_comb begin
    unique case (act_q)
      ACT_CLR: pin_nxt = 1'b0;
      ACT_SET: pin_nxt = 1'b1;
      ACT_TGL: pin_nxt = ~pin;
      default: pin_nxt = pin;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= 1'b0;
      act_q  <= ACT_KEEP;
    end else if (oc_wr) begin
      init_q <= oc_wdata[0];
      act_q  <= act_e'(oc_wdata[2:1]);
    end
  end

  // register write wins over a coincident match
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pin <= 1'b0;
    else if (oc_wr) pin <= oc_wdata[0];
    else if (match) pin <= pin_nxt;
  end

  p_oc_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    oc_wr |=> pin == $past(oc_wdata[0]));
  p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!oc_wr && match && act_q == ACT_KEEP) |=> $stable(pin));
  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!oc_wr && !match) |=> $stable(pin));
endmodule

// File: rtl/cc_mode_guard.sv
`timescale 1ns/1ps
module cc_mode_guard
  import cc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [2:0] wdata,
  output logic       run,
  output mode_e      mode
);
  mode_e req;
  logic  legal;

  assign req   = mode_e'(wdata[2:1]);
  assign legal = !run && (req != MODE_RSVD) &&
                 (req == MODE_NORMAL || mode == MODE_NORMAL || req == mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      mode <= MODE_NORMAL;
    end else if (ctrl_wr) begin
      run <= wdata[0];
      if (legal) mode <= req;
    end
  end

  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(mode));
  p_no_swap_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RSYNC) |=> mode != MODE_COMPL);
  p_no_swap_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_COMPL) |=> mode != MODE_RSYNC);
  p_no_rsvd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode != MODE_RSVD);
endmodule

// File: rtl/capcmp_channel.sv
`timescale 1ns/1ps
module capcmp_channel
  import cc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_in,
  input  logic             bus_t1,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic [CNT_W-1:0] cnt_o,
  output logic             cap_flag,
  output logic             cmp_pin
);
  localparam int PAD_OC   = CNT_W - 3;
  localparam int PAD_FLAG = CNT_W - 1;

  logic             t2_q;
  logic [1:0]       addr_q;
  logic             wr_gr, wr_oc, wr_ctrl, clr_flag;
  logic [CNT_W-1:0] cnt, gr;
  logic             run, match, init_q;
  act_e             act_q;
  mode_e            mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t2_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      t2_q   <= bus_t1;
      addr_q <= bus_addr;
    end
  end

  assign wr_gr    = t2_q && addr_q == A_GR;
  assign wr_oc    = t2_q && addr_q == A_OC;
  assign wr_ctrl  = t2_q && addr_q == A_CTRL;
  assign clr_flag = t2_q && addr_q == A_FLAG && bus_wdata[0];
  assign match    = run && (cnt == gr);

  cc_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt)
  );

  cc_capture_reg #(.W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .cnt(cnt),
    .wr_gr(wr_gr), .wdata(bus_wdata), .clr_flag(clr_flag),
    .gr(gr), .flag(cap_flag)
  );

  cc_pin_ctrl u_pin (
    .clk(clk), .rst_n(rst_n), .oc_wr(wr_oc), .oc_wdata(bus_wdata[2:0]),
    .match(match), .init_q(init_q), .act_q(act_q), .pin(cmp_pin)
  );

  cc_mode_guard u_mode (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(wr_ctrl), .wdata(bus_wdata[2:0]),
    .run(run), .mode(mode)
  );

  always_comb begin
    unique case (rd_addr)
      A_GR:    rd_data = gr;
      A_OC:    rd_data = {{PAD_OC{1'b0}}, act_q, init_q};
      A_CTRL:  rd_data = {{PAD_OC{1'b0}}, mode, run};
      default: rd_data = {{PAD_FLAG{1'b0}}, cap_flag};
    endcase
  end

  assign cnt_o = cnt;

  p_t2_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !t2_q |=> $stable(gr) || $past(cnt) == gr);
endmodule

// File: tb/sim_capcmp_channel.sv
`timescale 1ns/1ps
module sim_capcmp_channel;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cap_in = 1'b0;
  logic         bus_t1 = 1'b0;
  logic [1:0]   bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [1:0]   rd_addr = '0;
  logic [W-1:0] rd_data, cnt_o;
  logic         cap_flag, cmp_pin;

  always #2.5 clk = ~clk;

  capcmp_channel #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .bus_t1(bus_t1),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_addr(rd_addr),
    .rd_data(rd_data), .cnt_o(cnt_o), .cap_flag(cap_flag), .cmp_pin(cmp_pin)
  );

  int n_chk = 0;
  int n_fail = 0;

  // expected-value model built from the requirements
  logic [2:0]   m_sync;
  logic         m_t2;
  logic [1:0]   m_a;
  logic [W-1:0] m_cnt, m_gr;
  logic         m_flag, m_pin, m_init, m_run;
  logic [1:0]   m_act, m_mode;

  function automatic logic [1:0] f_mode(input logic run, input logic [1:0] cur, input logic [1:0] nw);
    if (run || nw == 2'b11) return cur;
    if (nw == 2'b00 || cur == 2'b00 || nw == cur) return nw;
    return cur;
  endfunction

  function automatic logic f_pin(input logic [1:0] act, input logic p);
    case (act)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return ~p;
      default: return p;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync <= '0; m_t2 <= 1'b0; m_a <= '0; m_cnt <= '0; m_gr <= '0;
      m_flag <= 1'b0; m_pin <= 1'b0; m_init <= 1'b0; m_run <= 1'b0;
      m_act <= '0; m_mode <= '0;
    end else begin
      logic edge_c, wr, match;
      edge_c = m_sync[1] & ~m_sync[2];
      wr     = m_t2;
      match  = m_run && (m_cnt == m_gr);
      m_sync <= {m_sync[1:0], cap_in};
      m_t2   <= bus_t1;
      m_a    <= bus_addr;
      if (m_run) m_cnt <= m_cnt + 16'd1;
      if (edge_c) m_gr <= m_cnt;
      else if (wr && m_a == 2'd0) m_gr <= bus_wdata;
      if (edge_c) m_flag <= 1'b1;
      else if (wr && m_a == 2'd3 && bus_wdata[0]) m_flag <= 1'b0;
      if (wr && m_a == 2'd1) begin
        m_pin <= bus_wdata[0]; m_init <= bus_wdata[0]; m_act <= bus_wdata[2:1];
      end else if (match) m_pin <= f_pin(m_act, m_pin);
      if (wr && m_a == 2'd2) begin
        m_run  <= bus_wdata[0];
        m_mode <= f_mode(m_run, m_mode, bus_wdata[2:1]);
      end
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
    rd_addr = a;
    #0.1;
    v = rd_data;
  endtask

  task automatic compare_all();
    logic [W-1:0] v;
    chk("R1 counter", cnt_o, m_cnt);
    chk("R5 pin", {15'd0, cmp_pin}, {15'd0, m_pin});
    chk("R3 flag port", {15'd0, cap_flag}, {15'd0, m_flag});
    rd(2'd0, v); chk("R2 R4 general register", v, m_gr);
    rd(2'd1, v); chk("R7 output control readback", v, {13'd0, m_act, m_init});
    rd(2'd2, v); chk("R8 control", v, {13'd0, m_mode, m_run});
    rd(2'd3, v); chk("R3 flag read", v, {15'd0, m_flag});
  endtask

  task automatic cyc(input logic t1, input logic [1:0] a, input logic [W-1:0] wd, input logic cap);
    bus_t1 = t1; bus_addr = a; bus_wdata = wd; cap_in = cap;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] wd);
    cyc(1'b1, a, '0, cap_in);
    cyc(1'b0, 2'd0, wd, cap_in);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] c, v;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R6 reset pin", {15'd0, cmp_pin}, 16'd0);
    chk("R1 reset count", cnt_o, 16'd0);
    compare_all();

    // start counting in normal mode
    wr(2'd2, 16'h0001);
    repeat (4) cyc(1'b0, 2'd0, '0, 1'b0);
    chk("R1 running", cnt_o, 16'd4);

    // capture in the data phase of a general-register write
    cyc(1'b0, 2'd0, '0, 1'b1);
    c = cnt_o;
    cyc(1'b1, 2'd0, '0, 1'b1);
    c = cnt_o;
    cyc(1'b0, 2'd0, 16'hBEEF, 1'b1);
    rd(2'd0, v);
    chk("R4 capture beats write", v, c);
    chk("R2 captured count", v, c);
    chk("R3 flag set by capture", {15'd0, cap_flag}, 16'd1);
    repeat (3) cyc(1'b0, 2'd0, '0, 1'b0);

    // clear flag racing a new capture: capture wins
    cyc(1'b0, 2'd0, '0, 1'b1);
    cyc(1'b1, 2'd3, '0, 1'b1);
    cyc(1'b0, 2'd0, 16'h0001, 1'b1);
    chk("R3 capture beats clear", {15'd0, cap_flag}, 16'd1);
    wr(2'd3, 16'h0001);
    chk("R3 flag cleared", {15'd0, cap_flag}, 16'd0);
    cyc(1'b0, 2'd0, '0, 1'b0);

    // action toggle, initial level 0
    wr(2'd1, 16'h0006);
    // output-control write on the match edge
    c = cnt_o;
    cyc(1'b1, 2'd0, '0, 1'b0);
    cyc(1'b0, 2'd0, c + 16'd6, 1'b0);
    repeat (3) cyc(1'b0, 2'd0, '0, 1'b0);
    cyc(1'b1, 2'd1, '0, 1'b0);
    cyc(1'b0, 2'd0, 16'h0006, 1'b0);
    chk("R6 write beats match", {15'd0, cmp_pin}, 16'd0);

    // plain match toggles the pin
    c = cnt_o;
    cyc(1'b1, 2'd0, '0, 1'b0);
    cyc(1'b0, 2'd0, c + 16'd4, 1'b0);
    repeat (3) cyc(1'b0, 2'd0, '0, 1'b0);
    chk("R5 toggle on match", {15'd0, cmp_pin}, 16'd1);
    rd(2'd1, v);
    chk("R7 readback is register not pin", v, 16'h0006);

    // mode guard
    wr(2'd2, 16'h0003);
    rd(2'd2, v); chk("R8 mode ignored while running", v, 16'h0001);
    wr(2'd2, 16'h0000);
    wr(2'd2, 16'h0002);
    rd(2'd2, v); chk("R8 mode accepted when stopped", v, 16'h0002);
    wr(2'd2, 16'h0004);
    rd(2'd2, v); chk("R9 direct swap rejected", v, 16'h0002);
    wr(2'd2, 16'h0000);
    wr(2'd2, 16'h0004);
    rd(2'd2, v); chk("R8 complementary via normal", v, 16'h0004);
    wr(2'd2, 16'h0006);
    rd(2'd2, v); chk("R9 reserved rejected", v, 16'h0004);
    wr(2'd2, 16'h0001);

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      logic t1, cp;
      logic [1:0] a;
      logic [W-1:0] d;
      t1 = ($urandom % 3) == 0;
      a  = 2'($urandom % 4);
      cp = (($urandom % 5) == 0) ? ~cap_in : cap_in;
      case ($urandom % 4)
        0: d = W'($urandom);
        1: d = m_cnt + W'($urandom % 8);
        2: d = W'($urandom % 8) | 16'h0001;
        default: d = W'($urandom % 8);
      endcase
      cyc(t1, a, d, cp);
    end
    finish_run();
  end
endmodule